// File: doc/BRIEF.md
# Shared Multi-Way Hashed Exact-Match Table

This block holds exact-match forwarding entries of two kinds in one memory: station (MAC) addresses for bridging and single-address host routes (/32 or /128 keys reduced to the key width). Keeping host routes here means the prefix table elsewhere does not have to hold them and can be smaller. Every entry has a valid bit, a one-bit kind tag, a key and a result word. The tag takes part in the compare, so the two kinds never alias.

A search key is folded by a fixed XOR hash into a row number. That row is read from every page at once, and the stored key of each page is compared in parallel. Lookups are pipelined: one may be issued on every clock, and each returns hit, page and result a fixed two edges later. A separate programming port takes insert and delete commands, one per clock, and acknowledges each on the next edge. The acknowledgement says whether the key was found, which page was used, and whether the row had no room.

Top module: `emt_table`

## Requirements
- R1: The row index is an XOR fold of the key: key bit b is XORed into index bit (b mod IDX_W). With the default IDX_W of 4, key bits 47 and 43 both select row 8.
- R2: A lookup presented with `lk_valid` high at a rising edge has its answer on `rsp_*` after the second rising edge from that one. A new lookup is accepted on every clock, and answers come back in issue order.
- R3: A lookup hits only when a page holds a valid entry at the hashed row whose tag and key both equal the search tag and key. On a hit, `rsp_page` gives that page and `rsp_result` gives its stored result.
- R4: On a miss, `rsp_hit`, `rsp_page` and `rsp_result` are all zero.
- R5: Every command with `op_valid` high is acknowledged on the next edge by `op_ack`. An insert (`op_del` = 0) of an absent key writes the lowest-numbered page whose entry at that row is invalid. It reports that page with `op_found` = 0 and `op_full` = 0.
- R6: An insert of an absent key into a row where all pages are valid sets `op_full`, leaves `op_found` at 0 and does not change the table.
- R7: An insert whose tag and key are already present overwrites that entry's result in place. It reports `op_found` = 1 and the existing page, and creates no second copy.
- R8: Entries with the same key and different tags (0 = MAC, 1 = host) are distinct. Each can be stored and found separately.
- R9: A delete (`op_del` = 1) of a present tag and key clears that entry's valid bit and reports `op_found` = 1 and its page. A delete of an absent entry reports `op_found` = 0 and changes nothing.
- R10: After reset the table is empty and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_tag | input | 1 | Lookup kind tag (0 MAC, 1 host) |
| lk_key | input | 48 | Lookup key |
| rsp_valid | output | 1 | Lookup answer strobe |
| rsp_hit | output | 1 | Lookup found a matching entry |
| rsp_page | output | PW | Page of the matching entry |
| rsp_result | output | 16 | Result of the matching entry |
| op_valid | input | 1 | Programming command strobe |
| op_del | input | 1 | 0 insert, 1 delete |
| op_tag | input | 1 | Command kind tag |
| op_key | input | 48 | Command key |
| op_result | input | 16 | Result to store on insert |
| op_ack | output | 1 | Command acknowledgement |
| op_found | output | 1 | Key was present |
| op_full | output | 1 | Insert refused, row has no free page |
| op_page | output | PW | Page written, updated or cleared |

## Verification
On every cycle the assertions check the two-edge lookup timing and the one-edge acknowledgement timing. They also check that at most one page matches a search, that a miss carries zero page and result, and that a full report only follows an insert and never comes with a found flag. Which page an insert picks, whether an entry is updated in place, whether same-key entries of different kinds stay apart, and where the hash places a key can only be shown by the bench's scenarios. Those scenarios fill every row, force collisions, delete entries and insert again, all against an independent model.

// File: rtl/emt_pkg.sv
package emt_pkg;
    parameter int EMT_KEY_W = 48;
    parameter int EMT_RES_W = 16;

    typedef struct packed {
        logic                 valid;
        logic                 tag;
        logic [EMT_KEY_W-1:0] key;
        logic [EMT_RES_W-1:0] res;
    } entry_t;
endpackage

// File: rtl/emt_hash.sv
module emt_hash #(
    parameter int KEY_W = 48,
    parameter int IDX_W = 4
) (
    input  logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int b = 0; b < KEY_W; b++) begin
            idx[b % IDX_W] = idx[b % IDX_W] ^ key[b];
        end
    end
endmodule

// File: rtl/emt_way_cmp.sv
module emt_way_cmp
    import emt_pkg::*;
#(
    parameter int PAGES = 4
) (
    input  entry_t [PAGES-1:0]   row,
    input  logic                 tag,
    input  logic [EMT_KEY_W-1:0] key,
    output logic [PAGES-1:0]     hitv,
    output logic [PAGES-1:0]     freev
);
    for (genvar p = 0; p < PAGES; p++) begin : g_way
        assign hitv[p]  = row[p].valid && (row[p].tag == tag) && (row[p].key == key);
        assign freev[p] = !row[p].valid;
    end
endmodule

// File: rtl/emt_first.sv
module emt_first #(
    parameter int N  = 4,
    parameter int NW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [NW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = NW'(i);
            end
        end
    end
endmodule

// File: rtl/emt_table.sv
module emt_table
    import emt_pkg::*;
#(
    parameter int PAGES = 4,
    parameter int IDX_W = 4,
    localparam int ROWS = 1 << IDX_W,
    localparam int PW   = (PAGES > 1) ? $clog2(PAGES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic                 lk_tag,
    input  logic [EMT_KEY_W-1:0] lk_key,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [PW-1:0]        rsp_page,
    output logic [EMT_RES_W-1:0] rsp_result,
    input  logic                 op_valid,
    input  logic                 op_del,
    input  logic                 op_tag,
    input  logic [EMT_KEY_W-1:0] op_key,
    input  logic [EMT_RES_W-1:0] op_result,
    output logic                 op_ack,
    output logic                 op_found,
    output logic                 op_full,
    output logic [PW-1:0]        op_page
);
    typedef struct packed {
        entry_t [PAGES-1:0][ROWS-1:0] tbl;
        logic                         rd_vld;
        logic                         rd_tag;
        logic [EMT_KEY_W-1:0]         rd_key;
        entry_t [PAGES-1:0]           rd_row;
        logic                         rsp_vld;
        logic                         rsp_hit;
        logic [PW-1:0]                rsp_pg;
        logic [EMT_RES_W-1:0]         rsp_res;
        logic                         ack;
        logic                         found;
        logic                         full;
        logic [PW-1:0]                opg;
    } state_t;

    state_t s_d, s_q;

    logic [IDX_W-1:0]   lk_idx, op_idx;
    entry_t [PAGES-1:0] op_row;
    logic [PAGES-1:0]   lk_hitv, lk_freev, op_hitv, op_freev;
    logic               lk_any, op_any, free_any;
    logic [PW-1:0]      lk_pg, op_pg, free_pg;

    emt_hash #(.KEY_W(EMT_KEY_W), .IDX_W(IDX_W)) u_hash_lk (.key(lk_key), .idx(lk_idx));
    emt_hash #(.KEY_W(EMT_KEY_W), .IDX_W(IDX_W)) u_hash_op (.key(op_key), .idx(op_idx));

    for (genvar p = 0; p < PAGES; p++) begin : g_oprow
        assign op_row[p] = s_q.tbl[p][op_idx];
    end

    emt_way_cmp #(.PAGES(PAGES)) u_cmp_lk (
        .row(s_q.rd_row), .tag(s_q.rd_tag), .key(s_q.rd_key),
        .hitv(lk_hitv), .freev(lk_freev));
    emt_way_cmp #(.PAGES(PAGES)) u_cmp_op (
        .row(op_row), .tag(op_tag), .key(op_key),
        .hitv(op_hitv), .freev(op_freev));

    emt_first #(.N(PAGES), .NW(PW)) u_pick_lk   (.vec(lk_hitv),  .any(lk_any),   .idx(lk_pg));
    emt_first #(.N(PAGES), .NW(PW)) u_pick_op   (.vec(op_hitv),  .any(op_any),   .idx(op_pg));
    emt_first #(.N(PAGES), .NW(PW)) u_pick_free (.vec(op_freev), .any(free_any), .idx(free_pg));

    always_comb begin
        s_d = s_q;
        // lookup stage 1: registered row read of every page
        s_d.rd_vld = lk_valid;
        s_d.rd_tag = lk_tag;
        s_d.rd_key = lk_key;
        for (int p = 0; p < PAGES; p++) begin
            s_d.rd_row[p] = s_q.tbl[p][lk_idx];
        end
        // lookup stage 2: compare and register the answer
        s_d.rsp_vld = s_q.rd_vld;
        s_d.rsp_hit = s_q.rd_vld && lk_any;
        s_d.rsp_pg  = (s_q.rd_vld && lk_any) ? lk_pg : '0;
        s_d.rsp_res = (s_q.rd_vld && lk_any) ? s_q.rd_row[lk_pg].res : '0;
        // programming port
        s_d.ack   = op_valid;
        s_d.found = 1'b0;
        s_d.full  = 1'b0;
        s_d.opg   = '0;
        if (op_valid) begin
            if (op_del) begin
                if (op_any) begin
                    s_d.tbl[op_pg][op_idx].valid = 1'b0;
                    s_d.found = 1'b1;
                    s_d.opg   = op_pg;
                end
            end else if (op_any) begin
                s_d.tbl[op_pg][op_idx].res = op_result;
                s_d.found = 1'b1;
                s_d.opg   = op_pg;
            end else if (free_any) begin
                s_d.tbl[free_pg][op_idx].valid = 1'b1;
                s_d.tbl[free_pg][op_idx].tag   = op_tag;
                s_d.tbl[free_pg][op_idx].key   = op_key;
                s_d.tbl[free_pg][op_idx].res   = op_result;
                s_d.opg = free_pg;
            end else begin
                s_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid  = s_q.rsp_vld;
    assign rsp_hit    = s_q.rsp_hit;
    assign rsp_page   = s_q.rsp_pg;
    assign rsp_result = s_q.rsp_res;
    assign op_ack     = s_q.ack;
    assign op_found   = s_q.found;
    assign op_full    = s_q.full;
    assign op_page    = s_q.opg;
endmodule

// File: rtl/emt_table_chk.sv
module emt_table_chk #(
    parameter int PAGES = 4,
    parameter int PW    = 2,
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [PW-1:0]    rsp_page,
    input logic [RES_W-1:0] rsp_result,
    input logic [PAGES-1:0] lk_hitv,
    input logic             op_valid,
    input logic             op_del,
    input logic             op_ack,
    input logic             op_found,
    input logic             op_full
);
    a_r2_issue_to_answer: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ##2 rsp_valid);
    a_r2_no_spurious_answer: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> ##2 !rsp_valid);
    a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hitv));
    a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_result == '0 && rsp_page == '0));
    a_r10_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit);
    a_r5_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> op_ack);
    a_r5_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !op_ack);
    a_r6_full_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        op_full |-> (op_ack && !op_found));
    a_r6_full_only_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_del) |=> !op_full);
endmodule

bind emt_table emt_table_chk #(.PAGES(PAGES), .PW(PW), .RES_W(emt_pkg::EMT_RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_page(rsp_page), .rsp_result(rsp_result),
    .lk_hitv(lk_hitv), .op_valid(op_valid), .op_del(op_del),
    .op_ack(op_ack), .op_found(op_found), .op_full(op_full));

// File: tb/emt_table_tb.sv
module emt_table_tb;
    localparam int PERIOD = 10;
    localparam int PAGES  = 4;
    localparam int IDX_W  = 4;
    localparam int ROWS   = 1 << IDX_W;
    localparam int PW     = 2;
    localparam int NLK    = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_tag = 1'b0;
    logic [47:0] lk_key = '0;
    logic        rsp_valid, rsp_hit;
    logic [PW-1:0] rsp_page;
    logic [15:0] rsp_result;
    logic        op_valid = 1'b0, op_del = 1'b0, op_tag = 1'b0;
    logic [47:0] op_key = '0;
    logic [15:0] op_result = '0;
    logic        op_ack, op_found, op_full;
    logic [PW-1:0] op_page;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    bit          mv [PAGES][ROWS];
    bit          mt [PAGES][ROWS];
    logic [47:0] mk [PAGES][ROWS];
    logic [15:0] mr [PAGES][ROWS];

    bit          q_tag [NLK];
    logic [47:0] q_key [NLK];

    always #(PERIOD/2) clk = ~clk;

    emt_table #(.PAGES(PAGES), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_key(lk_key),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_page(rsp_page), .rsp_result(rsp_result),
        .op_valid(op_valid), .op_del(op_del), .op_tag(op_tag), .op_key(op_key),
        .op_result(op_result), .op_ack(op_ack), .op_found(op_found), .op_full(op_full),
        .op_page(op_page));

    function automatic int fold(input logic [47:0] k);
        int h = 0;
        for (int b = 0; b < 48; b++) h = h ^ (int'(k[b]) << (b % IDX_W));
        return h;
    endfunction

    // key whose hash lands on row r, distinguished by salt
    function automatic logic [47:0] mkkey(input int r, input int salt);
        logic [47:0] k = 48'(salt) << 8 | 48'h5A_0000_0000_00;
        k[3:0] = 4'(r ^ fold(k));
        return k;
    endfunction

    function automatic int find(input bit t, input logic [47:0] k);
        int r = fold(k);
        for (int p = 0; p < PAGES; p++)
            if (mv[p][r] && mt[p][r] == t && mk[p][r] == k) return p;
        return -1;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_op(input string req, input bit del, input bit t,
                         input logic [47:0] k, input logic [15:0] res);
        int r = fold(k);
        int hp = find(t, k);
        int fp = -1;
        bit e_found = 0, e_full = 0;
        int e_pg = 0;
        for (int p = PAGES - 1; p >= 0; p--) if (!mv[p][r]) fp = p;
        if (del) begin
            if (hp >= 0) begin e_found = 1; e_pg = hp; mv[hp][r] = 0; end
        end else if (hp >= 0) begin
            e_found = 1; e_pg = hp; mr[hp][r] = res;
        end else if (fp >= 0) begin
            e_pg = fp; mv[fp][r] = 1; mt[fp][r] = t; mk[fp][r] = k; mr[fp][r] = res;
        end else e_full = 1;
        @(negedge clk);
        op_valid = 1; op_del = del; op_tag = t; op_key = k; op_result = res;
        @(negedge clk);
        op_valid = 0;
        chk({req, " ack"},   op_ack,   1);
        chk({req, " found"}, op_found, e_found);
        chk({req, " full"},  op_full,  e_full);
        chk({req, " page"},  op_page,  e_pg);
    endtask

    task automatic check_rsp(input string req, input bit t, input logic [47:0] k);
        int hp = find(t, k);
        int r = fold(k);
        chk({req, " valid"}, rsp_valid, 1);
        chk({req, " hit"},   rsp_hit, hp >= 0);
        chk({req, " page"},  rsp_page, hp >= 0 ? hp : 0);
        chk({req, " result"}, rsp_result, hp >= 0 ? mr[hp][r] : 0);
    endtask

    task automatic lookup(input string req, input bit t, input logic [47:0] k);
        @(negedge clk);
        lk_valid = 1; lk_tag = t; lk_key = k;
        @(negedge clk);
        lk_valid = 0;
        @(negedge clk);
        check_rsp(req, t, k);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < PAGES; p++)
            for (int r = 0; r < ROWS; r++) mv[p][r] = 0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 rsp_valid", rsp_valid, 0);
        chk("R10 rsp_hit",   rsp_hit,   0);
        chk("R10 op_ack",    op_ack,    0);
        rst_n = 1;
        lookup("R10 R4 empty lookup", 0, mkkey(7, 3));

        // R5: fill every page of every row with colliding MAC keys
        for (int r = 0; r < ROWS; r++)
            for (int p = 0; p < PAGES; p++)
                do_op("R5 fill", 0, 0, mkkey(r, r * 8 + p + 1), 16'(r * 16 + p + 100));

        // R6: row full, table unchanged
        for (int r = 0; r < ROWS; r++) begin
            do_op("R6 full insert", 0, 0, mkkey(r, r * 8 + 5), 16'hDEAD);
            lookup("R6 refused key absent", 0, mkkey(r, r * 8 + 5));
        end

        // R2 R3 R8: back-to-back lookups; every fifth uses the host tag and misses
        for (int i = 0; i < NLK; i++) begin
            int r = (i / 5) % ROWS;
            int p = i % 5;
            q_tag[i] = (p == 4);
            q_key[i] = mkkey(r, r * 8 + (p == 4 ? 1 : p + 1));
        end
        for (int i = 0; i < NLK + 2; i++) begin
            @(negedge clk);
            if (i >= 2) check_rsp("R2 R3 R8 pipelined", q_tag[i-2], q_key[i-2]);
            if (i < NLK) begin
                lk_valid = 1; lk_tag = q_tag[i]; lk_key = q_key[i];
            end else lk_valid = 0;
        end

        // R7: update in place
        do_op("R7 update", 0, 0, mkkey(3, 3 * 8 + 3), 16'hBEEF);
        lookup("R7 updated result", 0, mkkey(3, 3 * 8 + 3));

        // R9: delete present, then absent
        do_op("R9 delete present", 1, 0, mkkey(5, 5 * 8 + 2), 16'h0);
        do_op("R9 delete absent",  1, 0, mkkey(5, 5 * 8 + 2), 16'h0);
        lookup("R9 deleted misses", 0, mkkey(5, 5 * 8 + 2));
        lookup("R9 neighbour kept", 0, mkkey(5, 5 * 8 + 3));

        // R8: host entry with the same key as a MAC entry takes the freed page
        do_op("R8 R5 host insert", 0, 1, mkkey(5, 5 * 8 + 1), 16'h1234);
        lookup("R8 host lookup", 1, mkkey(5, 5 * 8 + 1));
        lookup("R8 mac lookup",  0, mkkey(5, 5 * 8 + 1));

        // R1: single-bit keys 47 and 43 both fold to row 8
        do_op("R1 free row 8", 1, 0, mkkey(8, 8 * 8 + 1), 16'h0);
        do_op("R1 bit47 lands row 8", 0, 0, 48'h1 << 47, 16'h4747);
        do_op("R1 bit43 row 8 full", 0, 0, 48'h1 << 43, 16'h4343);
        lookup("R1 bit47 lookup", 0, 48'h1 << 47);
        chk("R1 bit47 page", rsp_page, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule